// File: doc/BRIEF.md
# Standby and Wake-Up Controller

This block manages the low-power states of a small microcontroller core. When the core raises a halt request, the controller stalls the core. A mode bit selects what happens next. In halt mode the clock keeps running. In stop mode the oscillator enable is dropped. A 4-bit release operand is captured when standby begins. It names the single event that ends standby and the pin level that counts as that event. The event can be the serial input pin, the 8-bit key-scan port, the 4-bit key-sense port, or completion of the transmit down counter.

Pin levels are brought onto the clock through a two-stage synchronizer, and the synchronized value clears the stall. In stop mode the clock is assumed to be gated off, so the same release condition is also evaluated directly on the raw pins. That raw result turns the oscillator back on before the stall is cleared. If stop is requested while the transmit timer is still counting, the core stalls at once. The oscillator is dropped only after the timer goes idle.

An optional hang-up detector raises a reset request when the scan port is misconfigured during stop mode.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, `cpu_stall` is 0, `osc_en` is 1 and `hang_rst` is 0.
- R2: A `halt_req` seen while running raises `cpu_stall` on the next clock edge. A `halt_req` seen while already stalled has no effect.
- R3: With `stop_sel`=0 (halt mode), `osc_en` stays 1 for the whole standby.
- R4: With `stop_sel`=1 and `tmr_busy`=0 at the request, `osc_en` is 0 from the edge that raises the stall, unless the raw release condition is already true.
- R5: With `stop_sel`=1 and `tmr_busy`=1 at the request, the stall rises at once and `osc_en` stays 1. `osc_en` falls on the first edge at which `tmr_busy` is seen low.
- R6: `rel_op` bit 3 is the level: 1 wakes on high, 0 wakes on low. `rel_op[2:0]` selects the source: 000 serial pin, 001 scan port, 010 sense port, 100 timer; any other code never wakes. The operand is captured at entry, and later changes to `rel_op` have no effect until the next entry.
- R7: For the pin sources, a port wakes on high level when any of its pins is high, and on low level when any of its pins is low. After a pin change, `cpu_stall` falls on the third clock edge, because of the two-stage synchronizer.
- R8: The scan-port source wakes only while `scan_dir_out`=0 (input mode). In output mode it never wakes.
- R9: The timer source wakes when `tmr_done` is 1, whatever the level bit. The stall falls on the next edge.
- R10: With `shift_from_serial`=1 and the serial source selected, standby always releases: the stall falls on the second edge after the request.
- R11: In stop mode, `osc_en` follows the raw, unsynchronized release condition in the same cycle. The stall falls later, and `osc_en` stays 1 after the wake.
- R12: `hang_rst` is 1 only when `hang_en`=1, the controller is in stop mode, and either `scan_dir_out`=0 or any synchronized scan pin is low. In halt mode it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Request to enter standby |
| stop_sel | input | 1 | 0 = halt mode, 1 = stop mode |
| rel_op | input | 4 | Release operand: [3] level, [2:0] source |
| serial_pin | input | 1 | Serial input pin level |
| scan_pins | input | 8 | Key-scan port pin levels |
| scan_dir_out | input | 1 | Scan port direction, 1 = output |
| sense_pins | input | 4 | Key-sense port pin levels |
| shift_from_serial | input | 1 | Accumulator shift source is the serial pin |
| tmr_busy | input | 1 | Transmit down counter is running |
| tmr_done | input | 1 | Transmit down counter reached zero |
| hang_en | input | 1 | Enables the hang-up detector |
| cpu_stall | output | 1 | Holds the core in standby |
| osc_en | output | 1 | Oscillator enable |
| hang_rst | output | 1 | Hang-up reset request |

## Verification
Each fault in this block shows up at the ports within a few cycles:

- A wrongly captured source or level leaves `cpu_stall` high past the third edge after the pin change, or drops it too early.
- A state that skips the deferred stop phase clears `osc_en` in the cycle after a request made while the timer is busy.
- A wrong choice between the raw and synchronized paths shows at `osc_en` in the very cycle the pin moves.
- A wrong hang-up decode shows at `hang_rst` within two edges of a scan pin change.

// File: rtl/standby_pkg.sv
package standby_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_HALT  = 2'd1,
        PS_DEFER = 2'd2,
        PS_STOP  = 2'd3
    } pstate_e;

    typedef enum logic [2:0] {
        WS_SERIAL = 3'b000,
        WS_SCAN   = 3'b001,
        WS_SENSE  = 3'b010,
        WS_TIMER  = 3'b100
    } wsrc_e;

    typedef struct packed {
        logic  hi_lvl;
        wsrc_e src;
    } relop_t;

    // Level match on a port: high level needs any pin high, low level needs any pin low.
    function automatic logic lvl_hit(logic any_hi, logic all_hi, logic hi);
        return hi ? any_hi : !all_hi;
    endfunction

endpackage

// File: rtl/stb_sync.sv
module stb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/stb_wake_eval.sv
module stb_wake_eval
    import standby_pkg::*;
#(
    parameter int SCAN_W  = 8,
    parameter int SENSE_W = 4
) (
    input  relop_t             op,
    input  logic               serial_lvl,
    input  logic [SCAN_W-1:0]  scan_lvl,
    input  logic               scan_dir_out,
    input  logic [SENSE_W-1:0] sense_lvl,
    input  logic               shift_from_serial,
    input  logic               tmr_done,
    output logic               wake
);
    always_comb begin
        case (op.src)
            WS_SERIAL: wake = shift_from_serial |
                              lvl_hit(serial_lvl, serial_lvl, op.hi_lvl);
            WS_SCAN:   wake = !scan_dir_out &&
                              lvl_hit(|scan_lvl, &scan_lvl, op.hi_lvl);
            WS_SENSE:  wake = lvl_hit(|sense_lvl, &sense_lvl, op.hi_lvl);
            WS_TIMER:  wake = tmr_done;
            default:   wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int SCAN_W      = 8,
    parameter int SENSE_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req,
    input  logic               stop_sel,
    input  logic [3:0]         rel_op,
    input  logic               serial_pin,
    input  logic [SCAN_W-1:0]  scan_pins,
    input  logic               scan_dir_out,
    input  logic [SENSE_W-1:0] sense_pins,
    input  logic               shift_from_serial,
    input  logic               tmr_busy,
    input  logic               tmr_done,
    input  logic               hang_en,
    output logic               cpu_stall,
    output logic               osc_en,
    output logic               hang_rst
);
    localparam int SYN_W = 1 + SCAN_W + SENSE_W;

    pstate_e             state;
    relop_t              op_q;
    wsrc_e               src_q;
    logic [SYN_W-1:0]    pins_s;
    logic                serial_s;
    logic [SCAN_W-1:0]   scan_s;
    logic [SENSE_W-1:0]  sense_s;
    logic                wake_s;
    logic                wake_raw;

    stb_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({serial_pin, scan_pins, sense_pins}),
        .q   (pins_s)
    );

    assign {serial_s, scan_s, sense_s} = pins_s;
    assign src_q = op_q.src;

    // Synchronized path: ends the stall.
    stb_wake_eval #(.SCAN_W(SCAN_W), .SENSE_W(SENSE_W)) u_eval_sync (
        .op                (op_q),
        .serial_lvl        (serial_s),
        .scan_lvl          (scan_s),
        .scan_dir_out      (scan_dir_out),
        .sense_lvl         (sense_s),
        .shift_from_serial (shift_from_serial),
        .tmr_done          (tmr_done),
        .wake              (wake_s)
    );

    // Raw path: restarts a gated oscillator without needing a clock.
    stb_wake_eval #(.SCAN_W(SCAN_W), .SENSE_W(SENSE_W)) u_eval_raw (
        .op                (op_q),
        .serial_lvl        (serial_pin),
        .scan_lvl          (scan_pins),
        .scan_dir_out      (scan_dir_out),
        .sense_lvl         (sense_pins),
        .shift_from_serial (shift_from_serial),
        .tmr_done          (tmr_done),
        .wake              (wake_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_RUN;
            op_q  <= '{hi_lvl: 1'b0, src: WS_SERIAL};
        end else begin
            unique case (state)
                PS_RUN: begin
                    if (halt_req) begin
                        op_q <= relop_t'(rel_op);
                        if (!stop_sel)     state <= PS_HALT;
                        else if (tmr_busy) state <= PS_DEFER;
                        else               state <= PS_STOP;
                    end
                end
                PS_HALT, PS_STOP: begin
                    if (wake_s) state <= PS_RUN;
                end
                PS_DEFER: begin
                    if (wake_s)         state <= PS_RUN;
                    else if (!tmr_busy) state <= PS_STOP;
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    assign cpu_stall = (state != PS_RUN);
    assign osc_en    = (state != PS_STOP) || wake_raw;
    assign hang_rst  = hang_en && (state == PS_STOP) &&
                       (!scan_dir_out || !(&scan_s));
endmodule

// File: rtl/stb_chk.sv
module stb_chk (
    input logic       clk,
    input logic       rst,
    input logic       halt_req,
    input logic       stop_sel,
    input logic       tmr_busy,
    input logic       tmr_done,
    input logic       cpu_stall,
    input logic       osc_en,
    input logic       hang_rst,
    input logic [2:0] op_src
);
    a_r2_enter_stall: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && halt_req) |=> cpu_stall);

    a_r3_halt_keeps_osc: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && halt_req && !stop_sel) |=> osc_en);

    a_r5_defer_keeps_osc: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && halt_req && stop_sel && tmr_busy) |=> osc_en);

    a_r9_timer_wake: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && tmr_done && op_src == 3'b100) |=> !cpu_stall);

    a_r11_osc_on_after_wake: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_stall) |-> osc_en);

    a_r12_hang_only_stalled: assert property (@(posedge clk) disable iff (rst)
        hang_rst |-> cpu_stall);
endmodule

bind standby_ctrl stb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt_req  (halt_req),
    .stop_sel  (stop_sel),
    .tmr_busy  (tmr_busy),
    .tmr_done  (tmr_done),
    .cpu_stall (cpu_stall),
    .osc_en    (osc_en),
    .hang_rst  (hang_rst),
    .op_src    (src_q)
);

// File: tb/tb_standby_ctrl.sv
`timescale 1ns/1ps
module tb_standby_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_req = 1'b0;
    logic       stop_sel = 1'b0;
    logic [3:0] rel_op = 4'b0000;
    logic       serial_pin = 1'b0;
    logic [7:0] scan_pins = 8'hFF;
    logic       scan_dir_out = 1'b1;
    logic [3:0] sense_pins = 4'h0;
    logic       shift_from_serial = 1'b0;
    logic       tmr_busy = 1'b0;
    logic       tmr_done = 1'b0;
    logic       hang_en = 1'b0;
    logic       cpu_stall, osc_en, hang_rst;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        logic  stall;
        logic  osc;
        logic  hang;
        string tag;
    } exp_t;
    exp_t sb[$];

    standby_ctrl dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .stop_sel(stop_sel),
        .rel_op(rel_op), .serial_pin(serial_pin), .scan_pins(scan_pins),
        .scan_dir_out(scan_dir_out), .sense_pins(sense_pins),
        .shift_from_serial(shift_from_serial), .tmr_busy(tmr_busy),
        .tmr_done(tmr_done), .hang_en(hang_en), .cpu_stall(cpu_stall),
        .osc_en(osc_en), .hang_rst(hang_rst)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue the expected outputs for a future cycle.
    task automatic expect_at(int d, logic s, logic o, logic h, string tag);
        exp_t it;
        int   pos;
        it.at = cyc + d; it.stall = s; it.osc = o; it.hang = h; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > it.at) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endtask

    task automatic enter(logic mode, logic [3:0] op);
        rel_op   = op;
        stop_sel = mode;
        halt_req = 1'b1;
        tick(1);
        halt_req = 1'b0;
    endtask

    // Monitor side: compare each queued item in its cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t it;
                it = sb.pop_front();
                n_chk++;
                if ({cpu_stall, osc_en, hang_rst} !== {it.stall, it.osc, it.hang}) begin
                    n_bad++;
                    $display("FAIL %s cyc=%0d actual stall/osc/hang=%b%b%b expected=%b%b%b",
                             it.tag, cyc, cpu_stall, osc_en, hang_rst,
                             it.stall, it.osc, it.hang);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_at(0, 1'b0, 1'b1, 1'b0, "R1 reset state");
        tick(2);

        // Halt mode, serial high level; R2 ignore and R6 operand latch.
        expect_at(1, 1'b1, 1'b1, 1'b0, "R2 R3 enter halt");
        enter(1'b0, 4'b1000);
        tick(2);
        rel_op = 4'b1100; halt_req = 1'b1; tmr_done = 1'b1;
        expect_at(2, 1'b1, 1'b1, 1'b0, "R6 R2 latched operand, request ignored");
        tick(1); halt_req = 1'b0; tick(2); tmr_done = 1'b0; rel_op = 4'b1000;
        expect_at(2, 1'b1, 1'b1, 1'b0, "R7 serial high still synchronizing");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R7 serial high wake third edge");
        serial_pin = 1'b1;
        tick(5);

        // Serial low level.
        expect_at(1, 1'b1, 1'b1, 1'b0, "R2 enter serial low");
        enter(1'b0, 4'b0000);
        tick(2);
        expect_at(2, 1'b1, 1'b1, 1'b0, "R7 serial low synchronizing");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R7 serial low wake");
        serial_pin = 1'b0;
        tick(5);

        // Scan port, high level, input mode.
        scan_dir_out = 1'b0; scan_pins = 8'h00; tick(3);
        expect_at(1, 1'b1, 1'b1, 1'b0, "R2 enter scan");
        enter(1'b0, 4'b1001);
        tick(2);
        expect_at(3, 1'b0, 1'b1, 1'b0, "R7 scan high wake");
        scan_pins = 8'h10;
        tick(5);

        // Scan port in output mode never wakes, input mode does.
        scan_dir_out = 1'b1; scan_pins = 8'hFF; tick(3);
        expect_at(1, 1'b1, 1'b1, 1'b0, "R2 enter scan output mode");
        enter(1'b0, 4'b1001);
        tick(4);
        expect_at(0, 1'b1, 1'b1, 1'b0, "R8 output mode no wake");
        expect_at(1, 1'b0, 1'b1, 1'b0, "R8 input mode wakes");
        scan_dir_out = 1'b0;
        tick(4);

        // Sense port at both levels.
        sense_pins = 4'hF; tick(3);
        enter(1'b0, 4'b0010);
        tick(2);
        expect_at(2, 1'b1, 1'b1, 1'b0, "R7 sense low synchronizing");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R7 sense low wake");
        sense_pins = 4'hE;
        tick(5);
        sense_pins = 4'h0; tick(3);
        enter(1'b0, 4'b1010);
        tick(2);
        expect_at(2, 1'b1, 1'b1, 1'b0, "R7 sense high synchronizing");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R7 sense high wake");
        sense_pins = 4'h2;
        tick(5);

        // Timer source, level bit 0 ignored.
        expect_at(1, 1'b1, 1'b1, 1'b0, "R2 enter timer");
        enter(1'b0, 4'b0100);
        tick(3);
        expect_at(0, 1'b1, 1'b1, 1'b0, "R9 timer not done");
        expect_at(1, 1'b0, 1'b1, 1'b0, "R9 timer done wake");
        tmr_done = 1'b1;
        tick(1); tmr_done = 1'b0; tick(3);

        // Stop mode, timer idle, raw wake restarts the oscillator first.
        serial_pin = 1'b0; tick(3);
        expect_at(1, 1'b1, 1'b0, 1'b0, "R4 stop gates oscillator");
        enter(1'b1, 4'b1000);
        tick(2);
        expect_at(0, 1'b1, 1'b1, 1'b0, "R11 raw wake enables oscillator");
        expect_at(2, 1'b1, 1'b1, 1'b0, "R11 stall held while synchronizing");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R11 stall cleared after oscillator");
        serial_pin = 1'b1;
        tick(3); serial_pin = 1'b0; tick(3);

        // Deferred stop while the timer is busy.
        tmr_busy = 1'b1;
        expect_at(1, 1'b1, 1'b1, 1'b0, "R5 defer keeps oscillator");
        enter(1'b1, 4'b1000);
        tick(4);
        expect_at(0, 1'b1, 1'b1, 1'b0, "R5 still deferred");
        expect_at(1, 1'b1, 1'b0, 1'b0, "R5 stop after timer idle");
        tmr_busy = 1'b0;
        tick(3);
        expect_at(3, 1'b0, 1'b1, 1'b0, "R5 wake from stop");
        serial_pin = 1'b1;
        tick(4); serial_pin = 1'b0; tick(3);

        // Serial shift source forces release.
        shift_from_serial = 1'b1;
        expect_at(1, 1'b1, 1'b1, 1'b0, "R10 stall rises");
        expect_at(2, 1'b0, 1'b1, 1'b0, "R10 forced release");
        enter(1'b0, 4'b1000);
        tick(3);
        shift_from_serial = 1'b0;
        tick(2);

        // Hang-up detector.
        hang_en = 1'b1; scan_dir_out = 1'b0; tick(1);
        expect_at(1, 1'b1, 1'b0, 1'b1, "R12 input mode in stop");
        enter(1'b1, 4'b1000);
        tick(2);
        expect_at(0, 1'b1, 1'b1, 1'b1, "R12 hang held until wake");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R12 hang clears on wake");
        serial_pin = 1'b1;
        tick(4); serial_pin = 1'b0; scan_dir_out = 1'b1; scan_pins = 8'hFF; tick(3);
        expect_at(1, 1'b1, 1'b0, 1'b0, "R12 output mode pins high");
        enter(1'b1, 4'b1000);
        tick(2);
        expect_at(1, 1'b1, 1'b0, 1'b0, "R12 low pin synchronizing");
        expect_at(2, 1'b1, 1'b0, 1'b1, "R12 low pin triggers");
        scan_pins = 8'hFB;
        tick(3);
        expect_at(2, 1'b1, 1'b0, 1'b0, "R12 pins restored");
        scan_pins = 8'hFF;
        tick(3);
        expect_at(3, 1'b0, 1'b1, 1'b0, "R12 wake");
        serial_pin = 1'b1;
        tick(4); serial_pin = 1'b0; scan_dir_out = 1'b0; tick(3);
        expect_at(1, 1'b1, 1'b1, 1'b0, "R12 halt mode no hang");
        enter(1'b0, 4'b1000);
        tick(2);
        expect_at(3, 1'b0, 1'b1, 1'b0, "R3 halt wake");
        serial_pin = 1'b1;
        tick(4); serial_pin = 1'b0; hang_en = 1'b0; tick(3);

        while (sb.size() > 0) tick(1);
        tick(2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule